// File: doc/BRIEF.md
# Bus-Attached Serial Transmitter with Byte Queue

This block is a write-mostly peripheral on a pipelined single-cycle bus. A master programs a 31-bit setup word (the clock-per-bit divisor in its low bits) and then streams bytes into a small transmit queue. The queue drains through a framing shifter onto one serial line. Each byte goes out as a start bit, eight data bits and a stop bit.

Two level interrupts support flow control. The first is high while the queue is below half full, so a master can keep writing until it drops and then wait for it to rise again. The second is high while there is nothing left to send. An active-low clear-to-send input holds back the start of each new character. It never cuts a character that is already on the line. A setup write changes the bit period only from the next character onward.

Top module: `bus_serial_tx`

## Requirements
- R1: After synchronous reset the line is high, `o_ack` is low, `o_stall` is low, and both interrupts are high.
- R2: A transfer with `i_stb`=1, `i_we`=1 and `i_addr`=2'b11 places `i_wdata[7:0]` at the tail of the queue. The other data bits are ignored.
- R3: `o_stall` is always low, and `o_ack` is high exactly in the cycle after each cycle in which `i_stb` is high.
- R4: A character is sent as a 0 start bit, then eight data bits least significant first, then a 1 stop bit. Each bit lasts D clocks, where D is bits [23:0] of the setup word in force when the character began. The line is high whenever no character is in progress.
- R5: The setup word resets to the `INIT_SETUP` parameter. A write with `i_addr`=2'b00 loads `i_wdata[30:0]`. The new divisor applies from the next character that starts; a character already in progress keeps its divisor.
- R6: The queue holds 16 bytes and sends them in write order. A data write while 16 bytes are queued is dropped.
- R7: `o_fifo_half_int` is high exactly when fewer than 8 bytes are queued (not counting the byte in the shifter).
- R8: `o_tx_idle_int` is high exactly when the queue is empty and no character is in progress.
- R9: While `i_cts_n` is high, no new character starts. A character already started completes, and queued bytes go out once `i_cts_n` returns low.
- R10: Writes to addresses 2'b01 or 2'b10, and transfers with `i_we`=0, neither queue a byte nor change the setup word.
- R11: A read (`i_we`=0) with `i_addr`=2'b00 returns `{1'b0, setup}` on `o_rdata` with the ack. Any other read address returns the busy flag in bit 5 and the queued byte count in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_stb | input | 1 | Transfer strobe |
| i_we | input | 1 | Write enable |
| i_addr | input | 2 | Register address |
| i_wdata | input | 32 | Write data |
| o_ack | output | 1 | Transfer acknowledge, one cycle after strobe |
| o_stall | output | 1 | Stall, always low |
| o_rdata | output | 32 | Read data, valid with ack |
| i_cts_n | input | 1 | Active-low clear to send |
| o_tx | output | 1 | Serial output line |
| o_fifo_half_int | output | 1 | Queue below half full |
| o_tx_idle_int | output | 1 | Nothing left to transmit |

## Verification
The hardest case to reach from the ports is a setup write that lands while a character is on the line, with another byte already waiting behind it. The divisor change has to split cleanly at the character boundary. The stimulus waits until the line falls for the start bit, then writes a new divisor and queues one more byte. The serial decoder expects the old period for the first character and the new period for the second. A second directed sequence raises clear-to-send in the middle of a character. It then reads the status register to confirm that exactly one byte is still queued and has not been started.

// File: rtl/bus_serial_tx.sv
module bus_serial_tx #(
  parameter logic [30:0] INIT_SETUP = 31'd868,
  parameter int DEPTH_LOG2 = 4,
  parameter int DIV_W = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        i_stb,
  input  logic        i_we,
  input  logic [1:0]  i_addr,
  input  logic [31:0] i_wdata,
  output logic        o_ack,
  output logic        o_stall,
  output logic [31:0] o_rdata,
  input  logic        i_cts_n,
  output logic        o_tx,
  output logic        o_fifo_half_int,
  output logic        o_tx_idle_int
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int FRAME_BITS = 10;
  localparam int NB_W = $clog2(FRAME_BITS);
  localparam logic [DEPTH_LOG2:0] FULL_LVL = (DEPTH_LOG2+1)'(DEPTH);
  localparam logic [DEPTH_LOG2:0] HALF_LVL = (DEPTH_LOG2+1)'(DEPTH / 2);

  logic [30:0]           setup_q;
  logic [7:0]            mem [DEPTH];
  logic [DEPTH_LOG2:0]   wr_ptr, rd_ptr, fill;
  logic                  busy;
  logic [FRAME_BITS-1:0] shreg;
  logic [DIV_W-1:0]      cnt, cur_div;
  logic [NB_W-1:0]       nbits;

  assign o_stall = 1'b0;

  wire wr_cyc = i_stb && i_we && !o_stall;
  wire full   = (fill == FULL_LVL);
  wire empty  = (fill == '0);
  wire push   = wr_cyc && (i_addr == 2'b11) && !full;
  wire start  = !busy && !empty && !i_cts_n;

  assign fill            = wr_ptr - rd_ptr;
  assign o_tx            = busy ? shreg[0] : 1'b1;
  assign o_fifo_half_int = (fill < HALF_LVL);
  assign o_tx_idle_int   = empty && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_ack   <= 1'b0;
      o_rdata <= '0;
    end else begin
      o_ack <= i_stb && !o_stall;
      if (i_stb && !i_we)
        o_rdata <= (i_addr == 2'b00) ? {1'b0, setup_q} : 32'({busy, fill});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      setup_q <= INIT_SETUP;
    else if (wr_cyc && i_addr == 2'b00)
      setup_q <= i_wdata[30:0];
  end

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr[DEPTH_LOG2-1:0]] <= i_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push)  wr_ptr <= wr_ptr + 1'b1;
      if (start) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '1;
      cnt     <= '0;
      cur_div <= '0;
      nbits   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      shreg   <= {1'b1, mem[rd_ptr[DEPTH_LOG2-1:0]], 1'b0};
      cur_div <= setup_q[DIV_W-1:0];
      cnt     <= setup_q[DIV_W-1:0] - 1'b1;
      nbits   <= NB_W'(FRAME_BITS - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        if (nbits == '0) begin
          busy <= 1'b0;
        end else begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          nbits <= nbits - 1'b1;
          cnt   <= cur_div - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_ack_follows_r3: assert property (@(posedge clk) disable iff (rst)
    i_stb |=> o_ack);
  p_no_spurious_ack_r3: assert property (@(posedge clk) disable iff (rst)
    !i_stb |=> !o_ack);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_LVL);
  p_cts_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(i_cts_n));
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(cnt) != '0) |-> $stable(o_tx));
  p_idle_line_r8: assert property (@(posedge clk) disable iff (rst)
    o_tx_idle_int |-> o_tx);
endmodule

// File: tb/bus_serial_tx_test.sv
module bus_serial_tx_test;
  localparam int DIV0 = 12;
  localparam int DIV1 = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic i_stb = 1'b0, i_we = 1'b0, i_cts_n = 1'b0;
  logic [1:0] i_addr = '0;
  logic [31:0] i_wdata = '0;
  logic o_ack, o_stall, o_tx, o_fifo_half_int, o_tx_idle_int;
  logic [31:0] o_rdata;

  bus_serial_tx #(.INIT_SETUP(31'(DIV0))) uut (
    .clk(clk), .rst(rst), .i_stb(i_stb), .i_we(i_we), .i_addr(i_addr),
    .i_wdata(i_wdata), .o_ack(o_ack), .o_stall(o_stall), .o_rdata(o_rdata),
    .i_cts_n(i_cts_n), .o_tx(o_tx), .o_fifo_half_int(o_fifo_half_int),
    .o_tx_idle_int(o_tx_idle_int));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] sb_byte [0:1023];
  int sb_div [0:1023];
  int wr_i = 0, rd_i = 0, rx_count = 0;
  bit rx_busy = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_word(input bit busy, input int fill);
    return 32'({busy, 5'(fill)});
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input bit we);
    @(negedge clk);
    i_stb = 1'b1; i_we = we; i_addr = a; i_wdata = d;
    @(negedge clk);
    i_stb = 1'b0; i_we = 1'b0;
    chk(o_ack === 1'b1 && o_stall === 1'b0, "R3 ack/stall", {30'd0, o_ack, o_stall}, 32'd2);
  endtask

  task automatic push_byte(input logic [7:0] b, input int d, input bit expect_kept);
    if (expect_kept) begin
      sb_byte[wr_i] = b; sb_div[wr_i] = d; wr_i++;
    end
    bus_wr(2'b11, {$urandom() & 32'hFFFF_FF00} | 32'(b), 1'b1);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    i_stb = 1'b1; i_we = 1'b0; i_addr = a;
    @(negedge clk);
    i_stb = 1'b0;
    d = o_rdata;
    chk(o_ack === 1'b1, "R3 read ack", 32'(o_ack), 32'd1);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(o_tx_idle_int && !rx_busy));
    repeat (3) @(negedge clk);
  endtask

  logic [7:0] rb;
  int rd;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && o_tx === 1'b0) begin
        rx_busy = 1'b1;
        rd = (rd_i < wr_i) ? sb_div[rd_i] : DIV0;
        repeat (rd / 2) @(negedge clk);
        chk(o_tx === 1'b0, "R4 start bit", 32'(o_tx), 32'd0);
        for (int k = 0; k < 8; k++) begin
          repeat (rd) @(negedge clk);
          rb[k] = o_tx;
        end
        repeat (rd) @(negedge clk);
        chk(o_tx === 1'b1, "R4 stop bit", 32'(o_tx), 32'd1);
        if (rd_i < wr_i) begin
          chk(rb === sb_byte[rd_i], "R6 byte order/R4 data", 32'(rb), 32'(sb_byte[rd_i]));
          rd_i++;
        end else begin
          chk(1'b0, "R6 unexpected byte", 32'(rb), 32'hFFFF_FFFF);
        end
        rx_count++;
        rx_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
    end
  end

  logic [31:0] rv;
  int base;
  logic [7:0] b;
  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(o_tx === 1'b1, "R1 tx idle", 32'(o_tx), 32'd1);
    chk(o_ack === 1'b0 && o_stall === 1'b0, "R1 ack/stall", {30'd0, o_ack, o_stall}, 32'd0);
    chk(o_fifo_half_int === 1'b1 && o_tx_idle_int === 1'b1, "R1 interrupts",
        {30'd0, o_fifo_half_int, o_tx_idle_int}, 32'd3);
    bus_rd(2'b00, rv);
    chk(rv === 32'(DIV0), "R5 setup reset value / R11 readback", rv, 32'(DIV0));

    // R2/R4 simple directed bytes
    push_byte(8'h00, DIV0, 1);
    push_byte(8'hFF, DIV0, 1);
    push_byte(8'hA5, DIV0, 1);
    wait_idle();
    chk(rd_i == 3, "R2 bytes delivered", 32'(rd_i), 32'd3);

    // R10 ignored writes
    base = rx_count;
    bus_wr(2'b01, 32'h0000_0055, 1'b1);
    bus_wr(2'b10, 32'h0000_0066, 1'b1);
    bus_wr(2'b11, 32'h0000_0077, 1'b0);
    bus_wr(2'b00, 32'h0000_0003, 1'b0);
    repeat (300) @(negedge clk);
    chk(rx_count == base, "R10 no byte sent", 32'(rx_count), 32'(base));
    bus_rd(2'b11, rv);
    chk(rv === status_word(0, 0), "R10 status empty / R11", rv, status_word(0, 0));
    bus_rd(2'b00, rv);
    chk(rv === 32'(DIV0), "R10 setup unchanged", rv, 32'(DIV0));

    // R9 cts held high while idle
    i_cts_n = 1'b1;
    push_byte(8'h5A, DIV0, 1);
    repeat (100) @(negedge clk);
    chk(o_tx === 1'b1 && rx_count == base, "R9 blocked start", 32'(o_tx), 32'd1);
    chk(o_tx_idle_int === 1'b0, "R8 idle low with queued byte", 32'(o_tx_idle_int), 32'd0);
    i_cts_n = 1'b0;
    wait_idle();
    chk(rx_count == base + 1, "R9 resumed", 32'(rx_count), 32'(base + 1));

    // R9 cts raised mid-character
    base = rx_count;
    push_byte(8'h3C, DIV0, 1);
    push_byte(8'hC3, DIV0, 1);
    do @(negedge clk); while (o_tx !== 1'b0);
    i_cts_n = 1'b1;
    repeat (15 * DIV0) @(negedge clk);
    chk(rx_count == base + 1 && o_tx === 1'b1, "R9 current char completes only",
        32'(rx_count), 32'(base + 1));
    bus_rd(2'b11, rv);
    chk(rv === status_word(0, 1), "R9 one byte held / R11 status", rv, status_word(0, 1));
    i_cts_n = 1'b0;
    wait_idle();
    chk(rx_count == base + 2, "R9 held byte sent", 32'(rx_count), 32'(base + 2));

    // R6/R7 fill and overflow with cts high
    i_cts_n = 1'b1;
    base = rx_count;
    for (int k = 0; k < 18; k++) begin
      push_byte(8'(k * 13 + 1), DIV0, k < 16);
      if (k == 6)
        chk(o_fifo_half_int === 1'b1, "R7 seven queued", 32'(o_fifo_half_int), 32'd1);
      if (k == 7)
        chk(o_fifo_half_int === 1'b0, "R7 eight queued", 32'(o_fifo_half_int), 32'd0);
    end
    bus_rd(2'b11, rv);
    chk(rv === status_word(0, 16), "R6 capped at 16", rv, status_word(0, 16));
    i_cts_n = 1'b0;
    wait_idle();
    chk(rx_count == base + 16 && rd_i == wr_i, "R6 overflow dropped", 32'(rx_count), 32'(base + 16));
    chk(o_fifo_half_int === 1'b1 && o_tx_idle_int === 1'b1, "R7/R8 after drain",
        {30'd0, o_fifo_half_int, o_tx_idle_int}, 32'd3);

    // R5 setup written mid-character
    push_byte(8'hA5, DIV0, 1);
    do @(negedge clk); while (o_tx !== 1'b0);
    bus_wr(2'b00, {1'b1, 7'd0, 24'(DIV1)}, 1'b1);
    push_byte(8'h96, DIV1, 1);
    wait_idle();
    chk(rd_i == wr_i, "R5 boundary split", 32'(rd_i), 32'(wr_i));
    bus_rd(2'b00, rv);
    chk(rv === 32'(DIV1), "R5 setup write / R11", rv, 32'(DIV1));
    bus_wr(2'b00, 32'(DIV0), 1'b1);

    // random traffic with flow control
    for (int it = 0; it < 220; it++) begin
      if (($urandom() % 8) == 0) i_cts_n = ~i_cts_n;
      case ($urandom() % 4)
        0: bus_wr(2'($urandom() % 2 + 1), $urandom(), 1'b1);
        1, 2: begin
          if (o_fifo_half_int) begin
            b = 8'($urandom());
            push_byte(b, DIV0, 1);
          end
        end
        default: repeat ($urandom() % 30) @(negedge clk);
      endcase
    end
    i_cts_n = 1'b0;
    wait_idle();
    chk(rd_i == wr_i, "R6 random stream complete", 32'(rd_i), 32'(wr_i));
    chk(o_tx === 1'b1, "R4 idle line high", 32'(o_tx), 32'd1);

    done = 1'b1;
    summary();
  end
endmodule